// File: doc/BRIEF.md
# Two-Input Sampling Converter Host Sequencer

This block runs the host side of a serial sampling converter that has two analog inputs. A start request comes with a 2-bit input-select code, made of a single/differential bit and an odd/sign bit. The sequencer then opens a conversion window. It briefly drops the conversion strobe so that a fresh rising edge is seen, and holds the strobe high for a programmable number of system clocks. It then drops the strobe and generates sixteen serial clocks. On those clocks it sends the select code and gathers the 16-bit sample at the same time, most significant bit first.

The converter applies a select code to the conversion that follows, not to the current one. For this reason every returned sample carries a tag with the code sent one frame earlier. The first frame after reset has no earlier code, so its sample is flagged as stale. When the exchange ends, the strobe goes back high and stays there, which lets the converter fall into its low-power sleep until the next request.

Top module: `sar_link_host`

## Requirements
- R1: After reset the strobe `cnv_o` is high, `sck_o` is low, and `busy_o` and `res_valid_o` are low.
- R2: A start request accepted while idle raises `busy_o` on the next cycle. `cnv_o` is low for exactly one cycle and is then high for exactly CONV_CYCLES cycles.
- R3: Once `cnv_o` falls, exactly 16 rising edges of `sck_o` follow. Each high phase lasts SCK_HALF system clocks. `sck_o` is never high while `cnv_o` is high.
- R4: `sdo_o` carries select-code bit 1 (single/differential) at the first rising `sck_o` edge and bit 0 (odd/sign) at the second. It is 0 at rising edges 3 to 16.
- R5: `sdi_i` is sampled at each rising `sck_o` edge. The first sample becomes bit 15 of `res_data_o` and the sixteenth becomes bit 0.
- R6: `res_valid_o` pulses for one cycle after the 16th falling `sck_o` edge, with the gathered word on `res_data_o`. `busy_o` is low in that same cycle.
- R7: `res_mode_o` shows the select code sent in the previous frame. `res_stale_o` is 1 for the first frame after reset and 0 for every later frame.
- R8: A start request made while `busy_o` is high has no effect. Neither the code sent in the current frame nor the code reported as the next frame's tag changes.
- R9: `cnv_o` is high in the cycle in which `res_valid_o` is high, and it stays high until the next start request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a conversion and exchange |
| mode_i | input | 2 | Select code for the next conversion: bit 1 single/differential, bit 0 odd/sign |
| sdi_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Conversion strobe; high means convert, then sleep |
| sck_o | output | 1 | Serial clock to the converter |
| sdo_o | output | 1 | Serial data to the converter |
| busy_o | output | 1 | High from acceptance of a request until the result pulse |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 16 | Gathered sample |
| res_mode_o | output | 2 | Select code the sample was converted with |
| res_stale_o | output | 1 | Sample predates any code sent since reset |

## Verification
The bench runs a behavioural converter that drives a chosen 16-bit word, changes its bit on every falling serial clock, and records what the host sends on each rising edge. The words used are an alternating mix, a pattern with only the end bits set, all ones and all zeros. Together they separate bit order, shift direction, an off-by-one in the edge count and stuck lines. The four select codes are sent in a sequence in which each code differs from the one before it. This shows whether the tag is taken from the previous frame or from the current one. A clashing request made in the middle of a conversion shows whether a busy-time start can disturb the code or the pipeline.

// File: rtl/sar_link_pkg.sv
package sar_link_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_CONV = 2'd2,
        ST_XFER = 2'd3
    } seq_state_e;

    // bit of the select code driven after 'idx' falling edges; zero once past the code
    function automatic logic code_bit(input logic [CODE_W-1:0] code, input int unsigned idx);
        logic b;
        b = 1'b0;
        for (int k = 0; k < CODE_W; k++) begin
            if (idx == k) b = code[CODE_W-1-k];
        end
        return b;
    endfunction

endpackage

// File: rtl/sar_link_tick.sv
module sar_link_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [DW-1:0] div_d, div_q;
    logic          last;

    assign last   = (div_q == DW'(HALF - 1));
    assign tick_o = run_i && last;

    always_comb begin
        div_d = div_q;
        if (!run_i || last) div_d = '0;
        else                div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= DW'(HALF - 1)); // R3

endmodule

// File: rtl/sar_link_shreg.sv
module sar_link_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clr_i)        sh_d = '0;
        else if (shift_i) sh_d = {sh_q[W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign word_o = sh_q;

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !clr_i) |=> (sh_q[0] == $past(bit_i))); // R5

endmodule

// File: rtl/sar_link_host.sv
module sar_link_host #(
    parameter int CONV_CYCLES = 10,
    parameter int SCK_HALF    = 2,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic              sdi_i,
    output logic              cnv_o,
    output logic              sck_o,
    output logic              sdo_o,
    output logic              busy_o,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic [1:0]        res_mode_o,
    output logic              res_stale_o
);
    import sar_link_pkg::*;

    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam int BIT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic              cnv;
        logic              sck;
        logic              sdo;
        logic              busy;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] prev;
        logic              have_prev;
        logic [CODE_W-1:0] tag;
        logic              stale;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              tick;
    logic              run;
    logic              sh_clr;
    logic              sh_en;
    logic [DATA_W-1:0] sh_word;

    assign run = (r_q.st == ST_XFER);

    sar_link_tick #(.HALF(SCK_HALF)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    sar_link_shreg #(.W(DATA_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (sh_clr),
        .shift_i (sh_en),
        .bit_i   (sdi_i),
        .word_o  (sh_word)
    );

    always_comb begin
        r_d     = r_q;
        r_d.valid = 1'b0;
        sh_clr  = 1'b0;
        sh_en   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.cnv = 1'b1;
                r_d.sck = 1'b0;
                if (start_i) begin
                    r_d.st   = ST_GAP;
                    r_d.cnv  = 1'b0;
                    r_d.busy = 1'b1;
                    r_d.code = mode_i;
                    sh_clr   = 1'b1;
                end
            end
            ST_GAP: begin
                r_d.st  = ST_CONV;
                r_d.cnv = 1'b1;
                r_d.cnt = '0;
            end
            ST_CONV: begin
                if (r_q.cnt == CNT_W'(CONV_CYCLES - 1)) begin
                    r_d.st   = ST_XFER;
                    r_d.cnv  = 1'b0;
                    r_d.sck  = 1'b0;
                    r_d.bitn = '0;
                    r_d.sdo  = code_bit(r_q.code, 0);
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_XFER: begin
                if (tick) begin
                    if (!r_q.sck) begin
                        r_d.sck = 1'b1;
                        sh_en   = 1'b1;
                    end else begin
                        r_d.sck  = 1'b0;
                        r_d.bitn = r_q.bitn + 1'b1;
                        r_d.sdo  = code_bit(r_q.code, int'(r_q.bitn) + 1);
                        if (r_q.bitn == BIT_W'(DATA_W - 1)) begin
                            r_d.st        = ST_IDLE;
                            r_d.cnv       = 1'b1;
                            r_d.sdo       = 1'b0;
                            r_d.busy      = 1'b0;
                            r_d.valid     = 1'b1;
                            r_d.data      = sh_word;
                            r_d.tag       = r_q.prev;
                            r_d.stale     = !r_q.have_prev;
                            r_d.prev      = r_q.code;
                            r_d.have_prev = 1'b1;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= ST_IDLE;
            r_q.cnv       <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnv_o       = r_q.cnv;
    assign sck_o       = r_q.sck;
    assign sdo_o       = r_q.sdo;
    assign busy_o      = r_q.busy;
    assign res_valid_o = r_q.valid;
    assign res_data_o  = r_q.data;
    assign res_mode_o  = r_q.tag;
    assign res_stale_o = r_q.stale;

    AST_SCK_ONLY_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !cnv_o); // R3
    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !res_valid_o) |=> (busy_o && !cnv_o)); // R2
    AST_CONV_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CONV) |-> (cnv_o && (r_q.cnt <= CNT_W'(CONV_CYCLES - 1)))); // R2
    AST_CODE_THEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (r_q.bitn >= BIT_W'(CODE_W))) |-> !sdo_o); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o); // R6
    AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> !busy_o); // R6
    AST_PARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> cnv_o); // R9
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !res_valid_o) |=> $stable(r_q.code)); // R8

endmodule

// File: tb/sar_link_host_tb.sv
module sar_link_host_tb_top;
    localparam int CONV  = 10;
    localparam int HALF  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        sdi_i = 1'b0;
    logic        cnv_o, sck_o, sdo_o, busy_o, res_valid_o, res_stale_o;
    logic [15:0] res_data_o;
    logic [1:0]  res_mode_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    sar_link_host #(.CONV_CYCLES(CONV), .SCK_HALF(HALF), .DATA_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .sdi_i(sdi_i),
        .cnv_o(cnv_o), .sck_o(sck_o), .sdo_o(sdo_o), .busy_o(busy_o),
        .res_valid_o(res_valid_o), .res_data_o(res_data_o), .res_mode_o(res_mode_o),
        .res_stale_o(res_stale_o)
    );

    // results of the most recent frame
    logic [15:0] f_data, f_rx;
    logic [1:0]  f_tag;
    logic        f_stale, f_busy_next, f_sdo_bad, f_sck_bad, f_hi_bad, f_park, f_busy_at_valid, f_timeout;
    int          f_hrun, f_rises, f_gap;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [1:0] mode, input logic [15:0] word, input bit inject);
        logic pc, ps;
        int falls, bitpos, hi_cur, cyc;
        bit inj_on;
        falls = 0; bitpos = 0; hi_cur = 0; cyc = 0; inj_on = 0;
        f_rx = '0; f_hrun = 0; f_rises = 0; f_gap = 0;
        f_sdo_bad = 0; f_sck_bad = 0; f_hi_bad = 0; f_timeout = 0;
        @(negedge clk);
        pc = cnv_o; ps = sck_o;
        start_i = 1'b1; mode_i = mode;
        @(negedge clk);
        start_i = 1'b0;
        f_busy_next = busy_o;
        forever begin
            if (pc && !cnv_o) begin
                falls++;
                if (falls == 2) begin bitpos = 0; sdi_i = word[15]; end
            end
            if (!cnv_o && falls == 1) f_gap++;
            if (cnv_o && falls == 1) f_hrun++;
            if (cnv_o && sck_o) f_sck_bad = 1;
            if (!ps && sck_o) begin
                f_rises++;
                f_rx = {f_rx[14:0], sdo_o};
                if (f_rises > 2 && sdo_o) f_sdo_bad = 1;
            end
            if (sck_o) hi_cur++;
            if (ps && !sck_o) begin
                if (hi_cur != HALF) f_hi_bad = 1;
                hi_cur = 0;
                bitpos++;
                sdi_i = (bitpos < 16) ? word[15 - bitpos] : 1'b0;
            end
            if (inj_on) begin start_i = 1'b0; inj_on = 0; end
            if (inject && falls == 1 && f_hrun == 3) begin
                start_i = 1'b1; mode_i = ~mode; inj_on = 1;
            end
            if (res_valid_o) break;
            pc = cnv_o; ps = sck_o;
            cyc++;
            if (cyc > 2000) begin f_timeout = 1; break; end
            @(negedge clk);
        end
        start_i = 1'b0;
        f_data = res_data_o; f_tag = res_mode_o; f_stale = res_stale_o;
        f_park = cnv_o; f_busy_at_valid = busy_o;
        check(!f_timeout, "R6 frame completes (watchdog)", f_timeout, 0);
    endtask

    task automatic check_frame(input logic [1:0] mode, input logic [15:0] word,
                               input logic [1:0] exp_tag, input logic exp_stale);
        check(f_busy_next == 1'b1, "R2 busy after accept", f_busy_next, 1);
        check(f_gap == 1, "R2 strobe low gap", f_gap, 1);
        check(f_hrun == CONV, "R2 strobe high length", f_hrun, CONV);
        check(f_rises == 16, "R3 sck rising count", f_rises, 16);
        check(!f_hi_bad, "R3 sck high phase", f_hi_bad, 0);
        check(!f_sck_bad, "R3 sck low while strobe high", f_sck_bad, 0);
        check(f_rx[15:14] == mode, "R4 select code sent", f_rx[15:14], mode);
        check(!f_sdo_bad, "R4 data out zero after code", f_sdo_bad, 0);
        check(f_data == word, "R5 captured word", f_data, word);
        check(!f_busy_at_valid, "R6 busy low with valid", f_busy_at_valid, 0);
        check(f_tag == exp_tag, "R7 tag of previous code", f_tag, exp_tag);
        check(f_stale == exp_stale, "R7 stale flag", f_stale, exp_stale);
        check(f_park == 1'b1, "R9 strobe parked high", f_park, 1);
        @(negedge clk);
        check(res_valid_o == 1'b0, "R6 valid single cycle", res_valid_o, 0);
        repeat (5) @(negedge clk);
        check(cnv_o == 1'b1 && sck_o == 1'b0, "R9 strobe stays high idle", {cnv_o, sck_o}, 2'b10);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(cnv_o == 1'b1, "R1 strobe high after reset", cnv_o, 1);
        check(sck_o == 1'b0, "R1 sck low after reset", sck_o, 0);
        check(busy_o == 1'b0 && res_valid_o == 1'b0, "R1 busy/valid low", {busy_o, res_valid_o}, 0);
    endtask

    task automatic test_first_frame();
        run_frame(2'b10, 16'hA5C3, 0);
        check_frame(2'b10, 16'hA5C3, 2'b00, 1'b1);
    endtask

    task automatic test_pipeline();
        run_frame(2'b01, 16'h8001, 0);
        check_frame(2'b01, 16'h8001, 2'b10, 1'b0);
        run_frame(2'b11, 16'hFFFF, 0);
        check_frame(2'b11, 16'hFFFF, 2'b01, 1'b0);
        run_frame(2'b00, 16'h0000, 0);
        check_frame(2'b00, 16'h0000, 2'b11, 1'b0);
    endtask

    task automatic test_busy_reject();
        run_frame(2'b10, 16'h3C5A, 1);
        check_frame(2'b10, 16'h3C5A, 2'b00, 1'b0);
        // R8 the tag of the following frame must be the original code
        run_frame(2'b01, 16'h1234, 0);
        check_frame(2'b01, 16'h1234, 2'b10, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_first_frame();
        test_pipeline();
        test_busy_reject();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R6 global watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule